// File: doc/BRIEF.md
# Dual-Select Static Memory with Separate Data Buses

This block is a 256-word by 4-bit static storage array. It has its own write-data input bus and its own read-data output bus. The part is enabled only when two chip selects agree: one is active-low and the other is active-high. Using two selects of opposite polarity lets several copies share an address bus and be decoded without extra glue logic. A write enable and an output enable, both active-low, choose the operating mode. The read-data bus goes to high impedance in every mode except a read. Alongside it, a drive-enable output shows when the bus carries valid data.

Writes are taken on the rising clock edge while the write conditions hold. Reads are combinational from the current address and control inputs. During a write, the output path is loaded with the data being written. When the write enable is released with the address unchanged, the new word therefore appears at once, with no stale value shown first. The stored words are never cleared. The reset input clears only the output preconditioning state.

Top module: `dualsel_sram`

## Requirements
- R1: Every one of the 256 locations keeps its own 4-bit word. A word written at an address is read back unchanged from that address, and no other address is affected.
- R2: If `cs_lo_n` is 1 or `cs_hi` is 0, the block is in standby. `q_drive` is 0, `q` is 4'bzzzz, and no word is written, whatever the other inputs are.
- R3: If `cs_lo_n`=0, `cs_hi`=1 and `wr_n`=0, the value on `din` is written to `addr` at the rising clock edge. During that cycle `q_drive` is 0 and `q` is high impedance, whatever the value of `oe_n`.
- R4: If `cs_lo_n`=0, `cs_hi`=1, `wr_n`=1 and `oe_n`=0, `q_drive` is 1 and `q` equals the word stored at `addr`, non-inverted, in the same cycle.
- R5: If `cs_lo_n`=0, `cs_hi`=1, `wr_n`=1 and `oe_n`=1, `q_drive` is 0, `q` is high impedance, and the stored words are left unchanged.
- R6: In the cycle after a write, a read of the same address returns the word just written.
- R7: Repeated reads and idle cycles do not change any stored word.
- R8: Asserting `rst_n` low clears no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset of the output preconditioning state only |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q | output | 4 | Read data; high impedance unless reading |
| q_drive | output | 1 | High while `q` is driven |

## Verification
A write and a read can meet across the edge that ends a write. In the cycle after the commit, a read of the same address must already show the new word, whether that word comes from the preconditioning register or from the array. The bench provokes this by writing and then immediately reading the same address with fresh data, several times over. It judges the result against its own reference array. It also checks the reverse case: a write at an address other than the one preconditioned must not leak into a read of the old address.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_QUIET   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } dsr_mode_e;

  // Both selects must agree before any other control matters.
  function automatic logic part_selected(input logic lo_n, input logic hi);
    return (!lo_n) && hi;
  endfunction

  function automatic dsr_mode_e decode_mode(input logic lo_n, input logic hi,
                                            input logic wn, input logic on);
    dsr_mode_e m;
    if (!part_selected(lo_n, hi))  m = MODE_STANDBY;
    else if (!wn)                  m = MODE_WRITE;
    else if (!on)                  m = MODE_READ;
    else                           m = MODE_QUIET;
    return m;
  endfunction

endpackage

// File: rtl/dsr_mode_decode.sv
module dsr_mode_decode
  import dsr_pkg::*;
(
  input  logic      sel_lo_n,
  input  logic      sel_hi,
  input  logic      wen_n,
  input  logic      oen_n,
  output dsr_mode_e mode,
  output logic      do_write,
  output logic      do_read
);

  always_comb begin
    mode     = decode_mode(sel_lo_n, sel_hi, wen_n, oen_n);
    do_write = (mode == MODE_WRITE);
    do_read  = (mode == MODE_READ);
  end

endmodule

// File: rtl/dsr_array.sv
module dsr_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // One bit plane per data bit; each plane holds DEPTH cells.
  for (genvar g = 0; g < DATA_W; g++) begin : g_plane
    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata[g];
    end

    assign rdata[g] = cells[raddr];
  end

endmodule

// File: rtl/dsr_out_stage.sv
module dsr_out_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drive_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] word_o,
  output logic              drive_o,
  output logic              pre_hit
);

  logic [DATA_W-1:0] pre_word;
  logic [ADDR_W-1:0] pre_addr;
  logic              pre_valid;

  // Preconditioning: the output path captures the word being written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_valid <= 1'b0;
      pre_word  <= '0;
      pre_addr  <= '0;
    end else if (load) begin
      pre_valid <= 1'b1;
      pre_word  <= din;
      pre_addr  <= addr;
    end
  end

  assign pre_hit = pre_valid && (pre_addr == addr);
  assign word_o  = pre_hit ? pre_word : arr_word;
  assign drive_o = drive_req;

endmodule

// File: rtl/dualsel_sram.sv
module dualsel_sram
  import dsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              wr_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q,
  output logic              q_drive
);

  dsr_mode_e         mode_w;
  logic              commit_w;
  logic              read_w;
  logic              pre_hit_w;
  logic [DATA_W-1:0] arr_word_w;
  logic [DATA_W-1:0] out_word_w;

  dsr_mode_decode u_dec (
    .sel_lo_n (cs_lo_n),
    .sel_hi   (cs_hi),
    .wen_n    (wr_n),
    .oen_n    (oe_n),
    .mode     (mode_w),
    .do_write (commit_w),
    .do_read  (read_w)
  );

  dsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (commit_w),
    .waddr (addr),
    .wdata (din),
    .raddr (addr),
    .rdata (arr_word_w)
  );

  dsr_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (commit_w),
    .drive_req (read_w),
    .addr      (addr),
    .din       (din),
    .arr_word  (arr_word_w),
    .word_o    (out_word_w),
    .drive_o   (q_drive),
    .pre_hit   (pre_hit_w)
  );

  assign q = q_drive ? out_word_w : {DATA_W{1'bz}};

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              cs_lo_n,
  input logic              cs_hi,
  input logic              wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] q,
  input logic              q_drive,
  input logic              commit_w
);

  logic sel;
  assign sel = !cs_lo_n && cs_hi;

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!q_drive && !commit_w)); // R2

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_n) |-> (!q_drive && commit_w)); // R3

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_n && !oe_n) |-> q_drive); // R4

  AST_QUIET_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_n && oe_n) |-> (!q_drive && !commit_w)); // R5

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit_w) && sel && wr_n && !oe_n && addr == $past(addr))
      |-> (q == $past(din))); // R6

endmodule

bind dualsel_sram dsr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .din      (din),
  .cs_lo_n  (cs_lo_n),
  .cs_hi    (cs_hi),
  .wr_n     (wr_n),
  .oe_n     (oe_n),
  .q        (q),
  .q_drive  (q_drive),
  .commit_w (commit_w)
);

// File: tb/dualsel_sram_test.sv
module dualsel_sram_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic [3:0] din;
  logic       cs_lo_n, cs_hi, wr_n, oe_n;
  logic [3:0] q;
  logic       q_drive;

  logic [3:0] ref_mem [256];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dualsel_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .wr_n(wr_n), .oe_n(oe_n),
    .q(q), .q_drive(q_drive)
  );

  function automatic logic [3:0] pattern(input int a, input int salt);
    return 4'((a * 7 + salt + (a >> 3)) & 15);
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual drive/q=%b expected %b", req, act, exp);
    end
  endtask

  // Apply controls after the falling edge, sample 1 ns later (before rising edge).
  task automatic apply(input logic l, input logic h, input logic w, input logic o,
                       input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    cs_lo_n = l; cs_hi = h; wr_n = w; oe_n = o; addr = a; din = d;
    #1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] d, input logic o);
    apply(1'b0, 1'b1, 1'b0, o, a, d);
    check("R3", {q_drive, q}, 5'b0_zzzz);
    ref_mem[a] = d;
  endtask

  task automatic do_read(input string req, input logic [7:0] a);
    apply(1'b0, 1'b1, 1'b1, 1'b0, a, 4'h0);
    check(req, {q_drive, q}, {1'b1, ref_mem[a]});
  endtask

  task automatic t_reset_state;
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 4'h0);
    check("R2", {q_drive, q}, 5'b0_zzzz);
  endtask

  task automatic t_fill_all;
    for (int a = 0; a < 256; a++) do_write(8'(a), pattern(a, 3), a[0]);
    for (int a = 0; a < 256; a++) do_read("R1", 8'(a));
  endtask

  task automatic t_write_through;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a = 8'(k * 41 + 5);
      do_write(a, ~ref_mem[a], 1'b0);
      do_read("R6", a);
    end
    do_write(8'h10, 4'hA, 1'b0);
    do_write(8'h11, 4'h5, 1'b0);
    do_read("R6", 8'h10);
    do_read("R1", 8'h11);
  endtask

  task automatic t_standby_blocks;
    logic [7:0] a = 8'h33;
    logic [3:0] old = ref_mem[a];
    apply(1'b1, 1'b1, 1'b0, 1'b0, a, ~old);
    check("R2", {q_drive, q}, 5'b0_zzzz);
    apply(1'b0, 1'b0, 1'b0, 1'b0, a, ~old);
    check("R2", {q_drive, q}, 5'b0_zzzz);
    apply(1'b1, 1'b0, 1'b1, 1'b0, a, ~old);
    check("R2", {q_drive, q}, 5'b0_zzzz);
    do_read("R2", a);
  endtask

  task automatic t_output_disabled;
    logic [7:0] a = 8'hC4;
    apply(1'b0, 1'b1, 1'b1, 1'b1, a, ~ref_mem[a]);
    check("R5", {q_drive, q}, 5'b0_zzzz);
    apply(1'b0, 1'b1, 1'b1, 1'b1, a, 4'hF);
    check("R5", {q_drive, q}, 5'b0_zzzz);
    do_read("R5", a);
  endtask

  task automatic t_write_oe_ignored;
    do_write(8'h7E, 4'h9, 1'b0);
    do_write(8'h7F, 4'h6, 1'b1);
    do_read("R3", 8'h7E);
    do_read("R3", 8'h7F);
  endtask

  task automatic t_static_hold;
    for (int k = 0; k < 5; k++) do_read("R7", 8'h5A);
    for (int k = 0; k < 20; k++) apply(1'b1, 1'b0, 1'b1, 1'b1, 8'(k), 4'(k));
    for (int a = 0; a < 256; a += 17) do_read("R7", 8'(a));
  endtask

  task automatic t_reset_keeps;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a += 13) do_read("R8", 8'(a));
  endtask

  initial begin
    rst_n = 1'b0; cs_lo_n = 1'b1; cs_hi = 1'b0; wr_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_fill_all();
    t_write_through();
    t_standby_blocks();
    t_output_disabled();
    t_write_oe_ignored();
    t_static_hold();
    t_reset_keeps();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule